// File: doc/BRIEF.md
# Strobe-Timed Boxcar Decimator

This block low-pass filters one stream of signed samples with a moving sum over the most recent 1000 accepted samples, and decimates that stream. Each accepted sample is written into a circular history memory and added to an accumulator. At the same time the sample written 1000 samples earlier is read back and subtracted. The accumulator therefore always holds the sum over the current window.

Output timing is not set by an internal divide-by-N counter. A word leaves the block one cycle after each pulse on an external strobe, which comes from a time-locked reference. The effective decimation ratio (nominally 25 at a 500 kHz sample rate, giving 20 kHz) can therefore be fractional and can drift with that reference.

Until a full window of samples has been taken after reset, the missing history counts as zero and each output is marked not primed. The wide internal sum is clamped to the signed range of the output word.

Top module: `running_sum_decim`

## Requirements
- R1: After reset, and before the first strobe, sum_valid_o is 0, sum_data_o is 0 and sum_primed_o is 0.
- R2: sum_valid_o is 1 for exactly one cycle, the cycle after each cycle in which strobe_i is 1, and is 0 in all other cycles.
- R3: The emitted sum equals the two's complement sum of the most recent min(N, 1000) accepted samples, where N counts accepted samples since reset. A sample accepted in the same cycle as the strobe is included.
- R4: smp_data_i has no effect on the sum in any cycle where smp_valid_i is 0.
- R5: sum_primed_o, updated with each output word, is 1 exactly when at least 1000 samples have been accepted since reset, counting a sample in the strobe cycle. Before that point, missing history is treated as zero. Once 1 it stays 1 until reset.
- R6: A strobe with no sample accepted since the previous strobe emits the same sum again, with sum_valid_o set.
- R7: The sum is saturated to 24-bit signed. Values above 8388607 are output as 8388607, and values below -8388608 are output as -8388608.
- R8: sum_data_o and sum_primed_o hold their values in all cycles that do not follow a strobe.
- R9: Once the window is full, each new sample pushes out exactly the sample accepted 1000 samples before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample on smp_data_i is accepted this cycle |
| smp_data_i | input | 18 | Two's complement input sample |
| strobe_i | input | 1 | Output request from the external timebase |
| sum_valid_o | output | 1 | New output word this cycle |
| sum_data_o | output | 24 | Saturated window sum, two's complement |
| sum_primed_o | output | 1 | The window held a full 1000 samples when the word was taken |

## Verification
The bench goes after four corner cases.

- Priming edge: a strobe is issued after sample 999, then a strobe is issued together with sample 1000. A design that counted the coincident sample late, or read stale memory contents before the window filled, would show the wrong flag or a sum polluted with garbage.
- Repeated strobes with no sample in between: a design that pushed the accumulator only on a sample, or gated output on a new sample, would drop or change the word.
- Full-scale runs of both polarities: a design that truncated instead of clamping would show a wrapped value.
- Window slide: a constant block is followed by one distinct sample, so an off-by-one pointer subtracts the wrong entry.

Long random streams with irregular valid gaps and strobe spacing cover the general sum.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int unsigned DEF_DATA_W    = 18;
  localparam int unsigned DEF_SUM_W     = 24;
  localparam int unsigned DEF_WIN_LEN   = 1000;
  localparam int unsigned DEF_MEM_DEPTH = 1024;
endpackage

// File: rtl/rsd_hist_mem.sv
module rsd_hist_mem #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // read-before-write on the same slot: rd returns the leaving sample
  assign rd_data_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wr_data_i;
  end
endmodule

// File: rtl/rsd_win_ctrl.sv
module rsd_win_ctrl #(
  parameter int unsigned WIN_LEN = 1000,
  parameter int unsigned DEPTH   = 1024,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(WIN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic          full_o,
  output logic          primed_nxt_o
);
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] fill_q;

  assign ptr_o        = ptr_q;
  assign full_o       = (fill_q == CNT_W'(WIN_LEN));
  assign primed_nxt_o = full_o || (adv_i && fill_q == CNT_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (adv_i) begin
      ptr_q <= (ptr_q == AW'(WIN_LEN - 1)) ? '0 : ptr_q + 1'b1;
      if (!full_o) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsd_accum.sv
module rsd_accum #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ACC_W  = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             full_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [ACC_W-1:0] acc_nxt_o
);
  localparam int unsigned EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] old_eff;
  logic [ACC_W-1:0]  new_ext, old_ext;

  // unwritten history reads as zero until the window is full
  assign old_eff = full_i ? old_i : '0;
  assign new_ext = {{EXT_W{new_i[DATA_W-1]}}, new_i};
  assign old_ext = {{EXT_W{old_eff[DATA_W-1]}}, old_eff};

  assign acc_nxt_o = adv_i ? (acc_q + new_ext - old_ext) : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/rsd_emit.sv
module rsd_emit #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned SUM_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             primed_i,
  output logic             valid_o,
  output logic [SUM_W-1:0] data_o,
  output logic             primed_o
);
  logic [SUM_W-1:0] clamp;

  generate
    if (ACC_W > SUM_W) begin : g_sat
      logic [ACC_W-SUM_W:0] hi;
      logic                 ovf;
      assign hi    = acc_i[ACC_W-1:SUM_W-1];
      assign ovf   = !((&hi) || !(|hi));
      assign clamp = !ovf ? acc_i[SUM_W-1:0] :
                     acc_i[ACC_W-1] ? {1'b1, {(SUM_W-1){1'b0}}}
                                    : {1'b0, {(SUM_W-1){1'b1}}};
    end else begin : g_ext
      assign clamp = SUM_W'($signed(acc_i));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      data_o   <= '0;
      primed_o <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        data_o   <= clamp;
        primed_o <= primed_i;
      end
    end
  end
endmodule

// File: rtl/running_sum_decim.sv
module running_sum_decim
  import rsd_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned SUM_W     = DEF_SUM_W,
  parameter int unsigned WIN_LEN   = DEF_WIN_LEN,
  parameter int unsigned MEM_DEPTH = DEF_MEM_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              strobe_i,
  output logic              sum_valid_o,
  output logic [SUM_W-1:0]  sum_data_o,
  output logic              sum_primed_o
);
  localparam int unsigned AW    = $clog2(MEM_DEPTH);
  localparam int unsigned ACC_W = DATA_W + $clog2(WIN_LEN);

  logic [AW-1:0]     ptr;
  logic              full, primed_nxt;
  logic [DATA_W-1:0] old_smp;
  logic [ACC_W-1:0]  acc_nxt;

  rsd_win_ctrl #(.WIN_LEN(WIN_LEN), .DEPTH(MEM_DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(smp_valid_i),
    .ptr_o(ptr), .full_o(full), .primed_nxt_o(primed_nxt)
  );

  rsd_hist_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk_i(clk_i), .wr_en_i(smp_valid_i), .addr_i(ptr),
    .wr_data_i(smp_data_i), .rd_data_o(old_smp)
  );

  rsd_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(smp_valid_i), .full_i(full),
    .new_i(smp_data_i), .old_i(old_smp), .acc_nxt_o(acc_nxt)
  );

  rsd_emit #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_emit (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .acc_i(acc_nxt),
    .primed_i(primed_nxt), .valid_o(sum_valid_o), .data_o(sum_data_o),
    .primed_o(sum_primed_o)
  );
endmodule

// File: rtl/rsd_chk.sv
module rsd_chk #(
  parameter int unsigned SUM_W   = 24,
  parameter int unsigned WIN_LEN = 1000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             strobe_i,
  input logic             sum_valid_o,
  input logic [SUM_W-1:0] sum_data_o,
  input logic             sum_primed_o
);
  int unsigned seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 0;
    else if (smp_valid_i && seen_q < WIN_LEN) seen_q <= seen_q + 1;
  end

  // R2
  strobe_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> sum_valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !sum_valid_o);
  // R8
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(sum_data_o) && $stable(sum_primed_o)));
  // R6
  repeat_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !smp_valid_i && sum_valid_o) |=> sum_data_o == $past(sum_data_o));
  // R5
  primed_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> (sum_primed_o == (seen_q >= WIN_LEN)));
  // R5
  primed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_primed_o |=> sum_primed_o);
endmodule

bind running_sum_decim rsd_chk #(.SUM_W(SUM_W), .WIN_LEN(WIN_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .strobe_i(strobe_i), .sum_valid_o(sum_valid_o), .sum_data_o(sum_data_o),
  .sum_primed_o(sum_primed_o)
);

// File: tb/running_sum_decim_tb_top.sv
`timescale 1ns/1ps
module running_sum_decim_tb_top;
  localparam int WIN = 1000;
  localparam int MAXO = 8388607;
  localparam int MINO = -8388608;

  logic clk_i = 0, rst_ni = 0;
  logic smp_valid_i = 0, strobe_i = 0;
  logic [17:0] smp_data_i = '0;
  logic sum_valid_o, sum_primed_o;
  logic [23:0] sum_data_o;

  running_sum_decim dut_i (.*);

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int hist [WIN];
  int wp = 0, mcnt = 0;
  longint msum = 0;
  int last_data = 0;
  bit last_primed = 0;
  bit done = 0;

  function automatic int sat24(longint s);
    if (s > MAXO) return MAXO;
    if (s < MINO) return MINO;
    return int'(s);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic [17:0] d);
    int v = int'($signed(d));
    if (mcnt >= WIN) msum -= hist[wp];
    hist[wp] = v;
    msum += v;
    wp = (wp + 1) % WIN;
    if (mcnt < WIN) mcnt++;
  endtask

  // one cycle: drive, then check outputs after the edge
  task automatic step(bit v, logic [17:0] d, bit s, string req);
    @(negedge clk_i);
    smp_valid_i = v; smp_data_i = d; strobe_i = s;
    if (v) push(d);
    @(posedge clk_i); #2;
    if (s) begin
      chk({req, " R2 valid"}, sum_valid_o, 1);
      chk({req, " R3/R7 sum"}, $signed(sum_data_o), sat24(msum));
      chk({req, " R5 primed"}, sum_primed_o, mcnt >= WIN);
      last_data = int'($signed(sum_data_o));
      last_primed = sum_primed_o;
    end else begin
      if (sum_valid_o !== 1'b0) chk("R2 idle valid", sum_valid_o, 0);
      if (int'($signed(sum_data_o)) != last_data || sum_primed_o != last_primed)
        chk("R8 hold", $signed(sum_data_o), last_data);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1 valid", sum_valid_o, 0);
    chk("R1 data", sum_data_o, 0);
    chk("R1 primed", sum_primed_o, 0);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #2;
    chk("R1 after release", sum_valid_o, 0);
    // strobe with empty history
    step(0, '0, 1, "R6 empty");
    // R4: ignored data while not valid
    for (int i = 0; i < 20; i++) step(0, 18'($urandom), 0, "R4");
    step(0, 18'h1ffff, 1, "R4 ignored");
    // fill to 999 samples with random gaps and strobes
    while (mcnt < WIN - 1) begin
      bit v = ($urandom % 5) != 0;
      bit s = ($urandom % 25) == 0;
      step(v, 18'($urandom), s, "R3 fill");
    end
    step(0, '0, 1, "R5 at 999");
    step(1, 18'($urandom), 1, "R5 coincident 1000");
    step(0, '0, 1, "R6 repeat a");
    step(0, '0, 1, "R6 repeat b");
    // random sliding window
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit s = ($urandom % 20) == 0;
      step(v, 18'($urandom), s, "R9 random");
    end
    // saturation, positive then negative
    for (int i = 0; i < WIN; i++) step(1, 18'h1ffff, 0, "R7");
    step(0, '0, 1, "R7 pos");
    for (int i = 0; i < WIN; i++) step(1, 18'h20000, 0, "R7");
    step(0, '0, 1, "R7 neg");
    // directed slide
    for (int i = 0; i < WIN; i++) step(1, 18'd5, 0, "R9");
    step(0, '0, 1, "R9 flat");
    step(1, 18'd7, 1, "R9 slide");
    chk("R9 slide value", last_data, 5002);
    step(0, '0, 0, "R8");
    finish_up();
  end
endmodule